// File: doc/BRIEF.md
# Event Performance Monitor

This block counts processor activity for sampling-based profiling. It holds one free-running cycle counter and a parameterized set of event counters (four by default). Each event counter watches one of a bank of single-cycle event strobes, and an 8-bit code chosen by software selects which strobe it watches. A global enable gates every counter. A divide-by-64 option slows the cycle counter so that long intervals can be measured.

Software uses the block by writing the two's complement of a sample period into a counter. The counter then wraps to zero after that many events. A wrap sets a sticky overflow flag. When the matching interrupt-enable bit is set, the flag drives a level interrupt. The handler reads the flag register, writes the same value back to clear exactly the flags it saw, and reloads the counter.

All state is reached through a simple register port with an address, a write strobe, write data and registered read data.

Top module: `event_perf_monitor`

## Requirements
- R1: After a synchronous reset, all counters, the control bits, the interrupt enables and the flags are zero. The event-select register reads 0xFFFFFFFF, read data is zero and the interrupt output is low.
- R2: While control bit 0 (enable) is clear, no counter advances. Counting starts on the clock edge after the write that sets the bit.
- R3: A control write with bit 1 set zeroes every event counter. A control write with bit 2 set zeroes the cycle counter and its divide-by-64 prescaler. Both bits read back as zero, and a clear wins over an increment in the same cycle.
- R4: While control bit 3 is set, the cycle counter advances only on every 64th enabled clock. The prescaler counts enabled clocks only while this mode is on, and holds its value otherwise.
- R5: The control register keeps only bit 0 and bit 3. A read of the control register returns zero in every other bit position, whatever was written.
- R6: Register addresses are: 0 control, 1 cycle counter, 2 to 5 event counters 0 to 3, 6 event select, 7 interrupt enable, 8 overflow flags. Every other address reads zero. In the enable and flag registers, bit 0 is the cycle counter and bits 1 to 4 are event counters 0 to 3.
- R7: Event counter n takes its code from bits 8n+7:8n of the event-select register. A code k in the range 0x00 to 0x16 counts the clocks on which strobe input k is high. The unassigned codes 0x0E, 0x0F and 0x13, the code 0xFF and every code above 0x16 never count.
- R8: When a counter steps from 0xFFFFFFFF to 0, it sets its overflow flag. The flag stays set until software clears it.
- R9: A 1 written to a flag bit clears that flag, and a 0 leaves it unchanged. If a wrap and a clear of the same flag fall in the same cycle, the flag stays set.
- R10: The interrupt output is the OR over all counters of flag AND enable. It is registered and changes on the same edge as the flag and enable registers.
- R11: Every counter can be written through the port. A write takes priority over an increment in the same cycle, so a preload of -N wraps after N counted events.
- R12: Read data is registered. It shows, one clock after an address is presented, the contents that register held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| event_in | input | 23 | One-cycle event strobes, indexed by event code |
| irq | output | 1 | Level interrupt |

## Verification
The bench preloads a counter with a small negative value under a constant strobe. This checks that the wrap lands on the exact event. A design that lets the increment beat the write would wrap one event early or late. A clear of a flag is issued in the same cycle as that flag's wrap, and a design that lets the clear win would lose the sample and drop the interrupt. Unassigned and out-of-range codes run against random strobes, and a slip in decoding would make those counters move. In divide-by-64 mode the cycle counter is watched across a mid-run reset of the prescaler, where an off-by-one tick period or a prescaler left uncleared shows up as a drifting count.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CODE_W = 8;

  localparam int CTRL_EN     = 0;
  localparam int CTRL_EVCLR  = 1;
  localparam int CTRL_CYCCLR = 2;
  localparam int CTRL_DIV    = 3;

  // Event codes that carry no strobe
  function automatic logic code_assigned(input int k);
    return !(k == 'h0E || k == 'h0F || k == 'h13);
  endfunction
endpackage

// File: rtl/pmu_prescale.sv
module pmu_prescale #(
  parameter int DIV_W = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (run)    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && !clr && (cnt_q == {DIV_W{1'b1}});

  // R4: ticks are at least 2^DIV_W clocks apart, never back to back
  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/pmu_event_mux.sv
module pmu_event_mux #(
  parameter int NUM_IN = 23,
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] code,
  input  logic [NUM_IN-1:0] events,
  output logic              hit
);
  logic [NUM_IN-1:0] match;

  for (genvar k = 0; k < NUM_IN; k++) begin : g_code
    if (pmu_pkg::code_assigned(k)) begin : g_on
      assign match[k] = (code == CODE_W'(k)) && events[k];
    end else begin : g_off
      assign match[k] = 1'b0;
    end
  end

  assign hit = |match;

  // R7: at most one strobe is selected by a code
  always_comb a_one_match_r7: assert ($onehot0(match));
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         wrap
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst)       val_q <= '0;
    else if (load) val_q <= load_val;
    else if (clr)  val_q <= '0;
    else if (inc)  val_q <= val_q + 1'b1;
  end

  assign value = val_q;
  assign wrap  = inc && !load && !clr && (val_q == {W{1'b1}});

  // R11: a port write beats a same-cycle increment
  p_load_wins_r11: assert property (@(posedge clk) disable iff (rst)
    load |=> value == $past(load_val));
  // R8: a wrap lands on zero
  p_wrap_zero_r8: assert property (@(posedge clk) disable iff (rst)
    wrap |=> value == '0);
  // R2: with no increment, load or clear the value holds
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!inc && !load && !clr) |=> $stable(value));
endmodule

// File: rtl/event_perf_monitor.sv
module event_perf_monitor #(
  parameter int NUM_EVCNT = 4,
  parameter int CNT_W     = 32,
  parameter int NUM_IN    = 23,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int DIV_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_IN-1:0] event_in,
  output logic              irq
);
  import pmu_pkg::*;

  localparam int NCNT       = NUM_EVCNT + 1;
  localparam int SEL_W      = NUM_EVCNT * CODE_W;
  localparam int A_CTRL     = 0;
  localparam int A_CNT0     = 1;
  localparam int A_SEL      = A_CNT0 + NCNT;
  localparam int A_INTEN    = A_SEL + 1;
  localparam int A_FLAGS    = A_INTEN + 1;

  logic              en_q, div_q;
  logic [SEL_W-1:0]  sel_q;
  logic [NCNT-1:0]   inten_q, inten_d;
  logic [NCNT-1:0]   flags_q, flags_d;
  logic [NCNT-1:0]   load, clr, inc, wrap, w1c;
  logic [CNT_W-1:0]  cnt_val [NCNT];
  logic [NUM_EVCNT-1:0] hit;
  logic              ctrl_wr, tick;
  logic [DATA_W-1:0] rd_d;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(A_CTRL));

  // Control register
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      div_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q  <= reg_wdata[CTRL_EN];
      div_q <= reg_wdata[CTRL_DIV];
    end
  end

  // Event select and interrupt enable
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '1;
    end else if (reg_wr && reg_addr == ADDR_W'(A_SEL)) begin
      sel_q   <= reg_wdata[SEL_W-1:0];
    end
  end

  always_comb begin
    inten_d = inten_q;
    if (reg_wr && reg_addr == ADDR_W'(A_INTEN)) inten_d = reg_wdata[NCNT-1:0];
  end

  pmu_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (ctrl_wr && reg_wdata[CTRL_CYCCLR]),
    .run  (en_q && div_q),
    .tick (tick)
  );

  // Counter 0 is the cycle counter, 1..NUM_EVCNT the event counters
  assign inc[0] = en_q && (!div_q || tick);
  assign clr[0] = ctrl_wr && reg_wdata[CTRL_CYCCLR];

  for (genvar i = 0; i < NUM_EVCNT; i++) begin : g_ev
    pmu_event_mux #(.NUM_IN(NUM_IN), .CODE_W(CODE_W)) u_mux (
      .code   (sel_q[i*CODE_W +: CODE_W]),
      .events (event_in),
      .hit    (hit[i])
    );
    assign inc[i+1] = en_q && hit[i];
    assign clr[i+1] = ctrl_wr && reg_wdata[CTRL_EVCLR];
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    assign load[i] = reg_wr && (reg_addr == ADDR_W'(A_CNT0 + i));
    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (load[i]),
      .load_val (reg_wdata[CNT_W-1:0]),
      .clr      (clr[i]),
      .inc      (inc[i]),
      .value    (cnt_val[i]),
      .wrap     (wrap[i])
    );
  end

  // Overflow flags: write-one-to-clear, a new wrap wins
  assign w1c = (reg_wr && reg_addr == ADDR_W'(A_FLAGS)) ? reg_wdata[NCNT-1:0] : '0;
  assign flags_d = (flags_q & ~w1c) | wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      inten_q <= '0;
      irq     <= 1'b0;
    end else begin
      flags_q <= flags_d;
      inten_q <= inten_d;
      irq     <= |(flags_d & inten_d);
    end
  end

  // Read mux, registered
  always_comb begin
    rd_d = '0;
    if (reg_addr == ADDR_W'(A_CTRL)) begin
      rd_d[CTRL_EN]  = en_q;
      rd_d[CTRL_DIV] = div_q;
    end
    for (int i = 0; i < NCNT; i++) begin
      if (reg_addr == ADDR_W'(A_CNT0 + i)) rd_d = DATA_W'(cnt_val[i]);
    end
    if (reg_addr == ADDR_W'(A_SEL))   rd_d = DATA_W'(sel_q);
    if (reg_addr == ADDR_W'(A_INTEN)) rd_d = DATA_W'(inten_q);
    if (reg_addr == ADDR_W'(A_FLAGS)) rd_d = DATA_W'(flags_q);
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_d;
  end

  // R10: interrupt tracks enabled flags on the same edge
  p_irq_level_r10: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags_q & inten_q));
  // R8: flags are sticky without a flag-register write
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == ADDR_W'(A_FLAGS)) |=> (flags_q & $past(flags_q)) == $past(flags_q));
  // R9: a wrap always leaves its flag set
  p_wrap_sets_r9: assert property (@(posedge clk) disable iff (rst)
    (wrap != '0) |=> (flags_q & $past(wrap)) == $past(wrap));
  // R5: control reads carry only the stored bits
  p_ctrl_read_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_W'(A_CTRL)) |=> (reg_rdata & ~DATA_W'(32'h9)) == '0);
  // R2: cycle counter frozen while disabled
  p_disabled_r2: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !reg_wr) |=> $stable(cnt_val[0]));
endmodule

// File: tb/event_perf_monitor_test.sv
module event_perf_monitor_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [22:0] event_in = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [22:0] ev_force = '0;

  event_perf_monitor uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_in(event_in), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model state
  bit        m_en, m_div;
  int        m_pre;
  bit [31:0] m_cnt [5];
  bit [31:0] m_sel;
  bit [4:0]  m_inten, m_flags;
  bit [31:0] exp_rd;
  bit        exp_irq;

  function automatic bit [31:0] m_read(input bit [3:0] a);
    case (a)
      0: return {28'd0, m_div, 2'b00, m_en};
      1, 2, 3, 4, 5: return m_cnt[a-1];
      6: return m_sel;
      7: return {27'd0, m_inten};
      8: return {27'd0, m_flags};
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit counts(input bit [7:0] c, input bit [22:0] ev);
    if (c > 8'h16) return 0;
    if (c == 8'h0E || c == 8'h0F || c == 8'h13) return 0;
    return ev[c];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_div = 0; m_pre = 0; m_sel = 32'hFFFF_FFFF;
      m_inten = 0; m_flags = 0;
      for (int i = 0; i < 5; i++) m_cnt[i] = 0;
      exp_rd = 0; exp_irq = 0;
    end else begin
      bit [4:0] inc, ovf;
      bit tick;
      exp_rd = m_read(reg_addr);
      tick = m_en && m_div && (m_pre == 63);
      inc[0] = m_en && (!m_div || tick);
      for (int i = 0; i < 4; i++) inc[i+1] = m_en && counts(m_sel[8*i +: 8], event_in);
      ovf = 0;
      for (int i = 0; i < 5; i++) begin
        if (reg_wr && reg_addr == 4'(i+1)) m_cnt[i] = reg_wdata;
        else if (reg_wr && reg_addr == 0 && ((i == 0) ? reg_wdata[2] : reg_wdata[1])) m_cnt[i] = 0;
        else if (inc[i]) begin
          if (m_cnt[i] == 32'hFFFF_FFFF) ovf[i] = 1;
          m_cnt[i] = m_cnt[i] + 1;
        end
      end
      if (reg_wr && reg_addr == 0 && reg_wdata[2]) m_pre = 0;
      else if (m_en && m_div) m_pre = (m_pre + 1) % 64;
      if (reg_wr && reg_addr == 0) begin m_en = reg_wdata[0]; m_div = reg_wdata[3]; end
      if (reg_wr && reg_addr == 6) m_sel = reg_wdata;
      if (reg_wr && reg_addr == 7) m_inten = reg_wdata[4:0];
      if (reg_wr && reg_addr == 8) m_flags = m_flags & ~reg_wdata[4:0];
      m_flags = m_flags | ovf;
      exp_irq = |(m_flags & m_inten);
      started = 1;
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, expv);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      check(reg_rdata === exp_rd, "read data", reg_rdata, exp_rd);
      check(irq === exp_irq, "irq", {31'd0, irq}, {31'd0, exp_irq});
    end
  end

  task automatic wr(input bit [3:0] a, input bit [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    event_in = 23'($urandom) | ev_force;
  endtask

  task automatic idle(input int n, input bit sweep, input bit [3:0] a);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      reg_wr = 0;
      reg_addr = sweep ? 4'(k % 16) : a;
      event_in = 23'($urandom) | ev_force;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired (%s): actual hang expected finish", cur_req);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";          idle(16, 1, 0);
    cur_req = "R6";          idle(16, 1, 0);
    cur_req = "R2";
    wr(6, 32'h0706_0100);    idle(40, 1, 0);
    cur_req = "R7";
    wr(7, 32'h1F);
    wr(0, 32'h1);            idle(100, 1, 0);
    wr(6, 32'h160D_0500);    idle(100, 1, 0);
    wr(6, 32'hFF13_0F0E);    idle(80, 1, 0);
    wr(6, 32'h8017_1514);    idle(60, 1, 0);
    cur_req = "R11";
    wr(6, 32'hFFFF_FF00);
    ev_force = 23'h1;
    wr(2, 32'hFFFF_FFF6);    idle(8, 0, 2);
    cur_req = "R8";          idle(6, 0, 8);
    cur_req = "R10";         idle(4, 1, 0);
    cur_req = "R9";
    wr(8, 32'h1C);           idle(2, 0, 8);
    wr(8, 32'h02);           idle(2, 0, 8);
    wr(2, 32'hFFFF_FFFF);
    wr(8, 32'h02);           idle(4, 0, 8);
    wr(8, 32'h1F);
    cur_req = "R10";
    wr(7, 32'h00);
    wr(3, 32'hFFFF_FFFE);    idle(4, 0, 8);
    wr(7, 32'h01);           idle(4, 0, 7);
    ev_force = '0;
    cur_req = "R4";
    wr(0, 32'hD);            idle(300, 0, 1);
    wr(0, 32'h9);            idle(40, 0, 1);
    wr(0, 32'hD);            idle(140, 0, 1);
    wr(0, 32'h8);            idle(20, 0, 1);
    wr(0, 32'h9);            idle(100, 0, 1);
    cur_req = "R3";
    wr(0, 32'h3);            idle(4, 1, 0);
    wr(0, 32'h5);            idle(4, 0, 0);
    cur_req = "R5";
    wr(0, 32'hFFFF_FFFF);    idle(3, 0, 0);
    wr(0, 32'hFFFF_FFF0);    idle(3, 0, 0);
    cur_req = "R12";
    wr(1, 32'h1234_5678);    idle(20, 1, 0);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule